// File: doc/BRIEF.md
# Split-Cycle Byte/Word Memory Access Unit

This unit sits between an execution core and a byte-organised memory that is built as two byte-wide banks: one holds every even byte address, the other every odd byte address. The core hands it one request at a time: a byte or a 16-bit word, read or write, at any 20-bit byte address. The unit turns each request into one or two memory bus cycles, raises the right bank enables, and steers write data onto the matching byte lane. On reads it gathers the bytes into a little-endian result and returns them together. Little-endian means the lower address holds the low-order byte and the address plus one holds the high-order byte.

A mode input picks how wide the memory path is. In wide mode a word at an even address moves in one cycle across both banks. A word at an odd address is split into two byte cycles: the low-order byte goes first and the high-order byte second. In narrow mode the memory acts as a single byte-wide bank, so every word takes two cycles whatever its alignment. The core sees a single done pulse once the last cycle of its request has finished.

Top module: `split_bus_access`

## Requirements
- R1: Out of reset, `reqReady` is 1, and both `memValid` and `doneValid` are 0.
- R2: In wide mode, a word at an even address uses exactly one bus cycle. That cycle carries the request address with both `memEvenEn` and `memOddEn` set and the full word on `memWdata`/`memRdata`. Bits [7:0] carry the even-address byte and bits [15:8] the odd-address byte. Both enables are never set while the address is odd.
- R3: In wide mode, a word at an odd address uses exactly two bus cycles. The first is at the request address with only `memOddEn` set. The second is at the address plus one with only `memEvenEn` set. The word read back is {byte at address+1, byte at address}.
- R4: In wide mode, a byte access uses one cycle. At an even address it sets only `memEvenEn` and uses lane [7:0]. At an odd address it sets only `memOddEn` and uses lane [15:8]. A byte read returns the byte in `doneRdata[7:0]` with [15:8] at 0, and a byte write leaves the neighbouring byte unchanged.
- R5: For a misaligned word write in wide mode, the first cycle puts the word's low-order byte on lane [15:8], and the second cycle puts its high-order byte on lane [7:0].
- R6: In narrow mode, every bus cycle sets only `memEvenEn` and uses lane [7:0] at the full byte address. A word takes two cycles, at the address and then at the address plus one. A byte takes one cycle.
- R7: The address plus one of a split access is taken modulo 2^20, so a word at 0xFFFFF has its high-order byte at 0x00000.
- R8: `doneValid` is a single-cycle pulse in the cycle after the last bus handshake of the request, with the assembled read data on `doneRdata`. `reqReady` stays 0 from acceptance until after that pulse.
- R9: While `memValid` is 1 and `memReady` is 0, the address, enables and write data stay unchanged.
- R10: `narrowMode` is sampled when a request is accepted. Changing it during a request does not alter that request's cycle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| narrowMode | input | 1 | 1 selects the 8-bit single-bank memory path |
| reqValid | input | 1 | Core presents a request |
| reqReady | output | 1 | Unit is idle and accepts a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWord | input | 1 | 1 = 16-bit word, 0 = byte |
| reqAddr | input | 20 | Byte address |
| reqWdata | input | 16 | Write data; low-order byte in [7:0] |
| doneValid | output | 1 | One-cycle completion pulse |
| doneRdata | output | 16 | Assembled read data |
| memValid | output | 1 | Bus cycle active |
| memReady | input | 1 | Memory completes the current cycle |
| memWrite | output | 1 | Bus cycle direction |
| memAddr | output | 20 | Byte address of the bus cycle |
| memEvenEn | output | 1 | Even bank enable (single bank in narrow mode) |
| memOddEn | output | 1 | Odd bank enable |
| memWdata | output | 16 | Write lanes: [7:0] even bank, [15:8] odd bank |
| memRdata | input | 16 | Read lanes, same arrangement |

## Verification
The bench writes a misaligned word and reads it back both as aligned words and as single bytes. A design that put the bytes on the wrong lane or in the wrong order would leave swapped or foreign bytes at the two addresses. Byte writes are followed by reading the neighbouring byte, which catches a design that enables both banks. The bench counts the bus cycles of every request, so a design that did not split odd words, or did not split every word in narrow mode, shows the wrong count. Further tests cover a word at 0xFFFFF, where a design without the 20-bit wrap misplaces the high byte. They also cover a mode flip in the middle of a request and varied memory latency, which expose a design that samples the mode late or counts the done pulse at the wrong time.

// File: rtl/split_bus_pkg.sv
package split_bus_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES  = 2;
  localparam int DATA_W = BYTE_W * LANES;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2,
    ST_DONE   = 2'd3
  } busState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture the accepted request
    logic capture;  // a bus cycle handshake completes this clock
    logic advance;  // move on to the second half of a split access
  } ctrlStrobe_t;
endpackage

// File: rtl/split_bus_ctrl.sv
module split_bus_ctrl
  import split_bus_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memReady,
  input  logic        isSplit,
  output logic        reqReady,
  output logic        memValid,
  output logic        doneValid,
  output ctrlStrobe_t strobe
);
  busState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext      = state;
    strobe         = '0;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.load = 1'b1;
          stateNext   = ST_FIRST;
        end
      end
      ST_FIRST: begin
        if (memReady) begin
          strobe.capture = 1'b1;
          if (isSplit) begin
            strobe.advance = 1'b1;
            stateNext      = ST_SECOND;
          end else begin
            stateNext = ST_DONE;
          end
        end
      end
      ST_SECOND: begin
        if (memReady) begin
          strobe.capture = 1'b1;
          stateNext      = ST_DONE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign reqReady  = (state == ST_IDLE);
  assign memValid  = (state == ST_FIRST) || (state == ST_SECOND);
  assign doneValid = (state == ST_DONE);
endmodule

// File: rtl/split_bus_datapath.sv
module split_bus_datapath
  import split_bus_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              narrowMode,
  input  logic              reqWrite,
  input  logic              reqWord,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              isSplit,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memEvenEn,
  output logic              memOddEn,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] doneRdata
);
  logic [ADDR_W-1:0] addrQ;
  logic              wordQ, writeQ, narrowQ, phaseQ;
  logic [DATA_W-1:0] wdataQ;
  logic [BYTE_W-1:0] rdLo, rdHi;

  logic              fullWord;
  logic              laneHigh;
  logic [BYTE_W-1:0] byteOut, byteIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      wordQ   <= 1'b0;
      writeQ  <= 1'b0;
      narrowQ <= 1'b0;
      wdataQ  <= '0;
      phaseQ  <= 1'b0;
    end else if (strobe.load) begin
      addrQ   <= reqAddr;
      wordQ   <= reqWord;
      writeQ  <= reqWrite;
      narrowQ <= narrowMode;
      wdataQ  <= reqWdata;
      phaseQ  <= 1'b0;
    end else if (strobe.advance) begin
      phaseQ  <= 1'b1;
    end
  end

  // wrapping increment over the whole address width
  assign memAddr  = phaseQ ? addrQ + ADDR_W'(1) : addrQ;
  assign isSplit  = wordQ && (narrowQ || addrQ[0]);
  assign fullWord = wordQ && !isSplit;
  assign laneHigh = !narrowQ && memAddr[0];
  assign memWrite = writeQ;

  assign memEvenEn = fullWord || narrowQ || !memAddr[0];
  assign memOddEn  = fullWord || (!narrowQ && memAddr[0]);

  assign byteOut = (wordQ && phaseQ) ? wdataQ[DATA_W-1:BYTE_W] : wdataQ[BYTE_W-1:0];
  assign byteIn  = laneHigh ? memRdata[DATA_W-1:BYTE_W] : memRdata[BYTE_W-1:0];

  for (genvar ln = 0; ln < LANES; ln++) begin : gLane
    localparam logic LANE_HI = (ln != 0);
    assign memWdata[ln*BYTE_W +: BYTE_W] =
      fullWord              ? wdataQ[ln*BYTE_W +: BYTE_W] :
      (laneHigh == LANE_HI) ? byteOut : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdLo <= '0;
      rdHi <= '0;
    end else if (strobe.capture) begin
      if (fullWord) begin
        rdLo <= memRdata[BYTE_W-1:0];
        rdHi <= memRdata[DATA_W-1:BYTE_W];
      end else if (phaseQ) begin
        rdHi <= byteIn;
      end else begin
        rdLo <= byteIn;
        rdHi <= '0;
      end
    end
  end

  assign doneRdata = {rdHi, rdLo};
endmodule

// File: rtl/split_bus_access.sv
module split_bus_access
  import split_bus_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              narrowMode,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic              reqWord,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [15:0]       reqWdata,
  output logic              doneValid,
  output logic [15:0]       doneRdata,
  output logic              memValid,
  input  logic              memReady,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memEvenEn,
  output logic              memOddEn,
  output logic [15:0]       memWdata,
  input  logic [15:0]       memRdata
);
  ctrlStrobe_t strobe;
  logic        isSplit;

  split_bus_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .memReady  (memReady),
    .isSplit   (isSplit),
    .reqReady  (reqReady),
    .memValid  (memValid),
    .doneValid (doneValid),
    .strobe    (strobe)
  );

  split_bus_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .narrowMode (narrowMode),
    .reqWrite   (reqWrite),
    .reqWord    (reqWord),
    .reqAddr    (reqAddr),
    .reqWdata   (reqWdata),
    .memRdata   (memRdata),
    .isSplit    (isSplit),
    .memWrite   (memWrite),
    .memAddr    (memAddr),
    .memEvenEn  (memEvenEn),
    .memOddEn   (memOddEn),
    .memWdata   (memWdata),
    .doneRdata  (doneRdata)
  );
endmodule

// File: rtl/split_bus_checker.sv
module split_bus_checker #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              memValid,
  input logic              memReady,
  input logic              memEvenEn,
  input logic              memOddEn,
  input logic [ADDR_W-1:0] memAddr,
  input logic [15:0]       memWdata,
  input logic              doneValid
);
  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady |=> memValid && $stable(memAddr) && $stable(memEvenEn)
                              && $stable(memOddEn) && $stable(memWdata));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R8
  done_after_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> $past(memValid && memReady));

  // R8
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> !reqReady);

  // R2
  both_even_chk: assert property (@(posedge clk) disable iff (!rstN)
    memValid && memEvenEn && memOddEn |-> !memAddr[0]);

  // R4
  some_bank_chk: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> (memEvenEn || memOddEn));
endmodule

bind split_bus_access split_bus_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqReady  (reqReady),
  .memValid  (memValid),
  .memReady  (memReady),
  .memEvenEn (memEvenEn),
  .memOddEn  (memOddEn),
  .memAddr   (memAddr),
  .memWdata  (memWdata),
  .doneValid (doneValid)
);

// File: tb/tb_split_bus_access.sv
`timescale 1ns/1ps
module tb_split_bus_access;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        narrowMode = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic        reqWord = 1'b0;
  logic [19:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic        doneValid;
  logic [15:0] doneRdata;
  logic        memValid;
  logic        memReady = 1'b0;
  logic        memWrite;
  logic [19:0] memAddr;
  logic        memEvenEn, memOddEn;
  logic [15:0] memWdata;
  logic [15:0] memRdata = '0;

  always #2 clk = ~clk;

  split_bus_access dut (.*);

  typedef struct {
    logic        isRead;
    logic [15:0] rdata;
    int          cycles;
    string       tag;
  } expItem_t;

  expItem_t    expQ[$];
  logic [7:0]  model[256];
  logic [7:0]  refMem[256];
  int          checks = 0;
  int          errors = 0;
  int          latency = 0;
  int          waitCnt = 0;
  logic        curNarrow = 1'b0;
  int          busTotal = 0;
  int          busMark = 0;
  logic        prevDone = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: ready and read data at negedge
  always @(negedge clk) begin
    if (memReady) begin
      memReady = 1'b0;
      waitCnt  = latency;
    end else if (memValid) begin
      if (waitCnt == 0) begin
        memReady = 1'b1;
        if (curNarrow)
          memRdata = {8'hEE, model[memAddr[7:0]]};
        else
          memRdata = {model[{memAddr[7:1], 1'b1}], model[{memAddr[7:1], 1'b0}]};
      end else begin
        waitCnt--;
      end
    end else begin
      waitCnt = latency;
    end
  end

  // memory model: write and cycle count at posedge
  always @(posedge clk) begin
    if (memValid && memReady) begin
      busTotal++;
      if (curNarrow) begin
        check(!memOddEn && memEvenEn, "R6 narrow enables", {memEvenEn, memOddEn}, 2'b10);
        if (memWrite) model[memAddr[7:0]] = memWdata[7:0];
      end else if (memWrite) begin
        if (memEvenEn) model[{memAddr[7:1], 1'b0}] = memWdata[7:0];
        if (memOddEn)  model[{memAddr[7:1], 1'b1}] = memWdata[15:8];
      end
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (prevDone && doneValid)
        check(1'b0, "R8 done pulse width", 2, 1);
      if (doneValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R8 unexpected done", 1, 0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check(busTotal - busMark == it.cycles, {it.tag, " cycles"}, busTotal - busMark, it.cycles);
          if (it.isRead)
            check(doneRdata == it.rdata, {it.tag, " rdata"}, doneRdata, it.rdata);
          check(!reqReady, "R8 not ready during done", reqReady, 0);
        end
        busMark = busTotal;
      end
    end
    prevDone = doneValid;
  end

  task automatic doReq(input bit wr, input bit wd, input logic [19:0] a, input logic [15:0] d,
                       input bit nar, input int lat, input string tag);
    expItem_t it;
    logic [7:0] i0, i1;
    while (!reqReady) @(negedge clk);
    i0 = a[7:0];
    i1 = 8'(a[7:0] + 8'd1);
    it.isRead = !wr;
    it.cycles = (wd && (nar || a[0])) ? 2 : 1;
    it.tag    = tag;
    it.rdata  = wd ? {refMem[i1], refMem[i0]} : {8'h00, refMem[i0]};
    if (wr) begin
      refMem[i0] = d[7:0];
      if (wd) refMem[i1] = d[15:8];
    end
    expQ.push_back(it);
    latency    = lat;
    curNarrow  = nar;
    narrowMode = nar;
    reqWrite   = wr;
    reqWord    = wd;
    reqAddr    = a;
    reqWdata   = d;
    reqValid   = 1'b1;
    @(negedge clk);
    reqValid   = 1'b0;
    while (expQ.size() != 0) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      model[i]  = 8'(i * 7 + 3);
      refMem[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    // R1
    check(reqReady && !memValid && !doneValid, "R1 reset state",
          {reqReady, memValid, doneValid}, 3'b100);
    rstN = 1'b1;
    @(negedge clk);

    // R2 aligned word
    doReq(1, 1, 20'h00010, 16'hA55A, 0, 0, "R2 aligned write");
    doReq(0, 1, 20'h00010, 16'h0,    0, 2, "R2 aligned read");
    // R4 byte lanes
    doReq(1, 0, 20'h00020, 16'h0011, 0, 1, "R4 even byte write");
    doReq(1, 0, 20'h00023, 16'h0077, 0, 0, "R4 odd byte write");
    doReq(0, 1, 20'h00020, 16'h0,    0, 0, "R4 neighbour of even byte");
    doReq(0, 1, 20'h00022, 16'h0,    0, 1, "R4 neighbour of odd byte");
    doReq(0, 0, 20'h00023, 16'h0,    0, 0, "R4 odd byte read");
    // R3 R5 misaligned word
    doReq(1, 1, 20'h00031, 16'hBEEF, 0, 1, "R5 misaligned write");
    doReq(0, 1, 20'h00030, 16'h0,    0, 0, "R5 low byte landed on odd bank");
    doReq(0, 1, 20'h00032, 16'h0,    0, 0, "R5 high byte landed on even bank");
    doReq(0, 1, 20'h00031, 16'h0,    0, 2, "R3 misaligned read");
    doReq(0, 0, 20'h00032, 16'h0,    0, 0, "R3 byte at address plus one");
    // R7 wrap
    doReq(1, 1, 20'hFFFFF, 16'h1234, 0, 0, "R7 wrap write");
    doReq(0, 0, 20'h00000, 16'h0,    0, 0, "R7 wrapped high byte");
    doReq(0, 1, 20'hFFFFF, 16'h0,    0, 1, "R7 wrap read");
    // R6 narrow mode
    doReq(1, 1, 20'h00040, 16'hC3D4, 1, 0, "R6 narrow aligned write");
    doReq(0, 1, 20'h00040, 16'h0,    1, 1, "R6 narrow aligned read");
    doReq(0, 1, 20'h00040, 16'h0,    0, 0, "R6 wide view of narrow write");
    doReq(0, 0, 20'h00041, 16'h0,    1, 0, "R6 narrow odd byte read");
    doReq(1, 1, 20'h00045, 16'h9182, 1, 2, "R6 narrow misaligned write");
    doReq(0, 1, 20'h00045, 16'h0,    0, 0, "R6 wide readback of narrow split");
    // R10 mode flip during a request
    fork
      doReq(0, 1, 20'h00050, 16'h0, 1, 2, "R10 mode flip");
      begin
        while (!memValid) @(negedge clk);
        narrowMode = 1'b0;
      end
    join
    repeat (4) @(negedge clk);
    // R8 idle after completion
    check(reqReady && !memValid && !doneValid, "R8 idle after last request",
          {reqReady, memValid, doneValid}, 3'b100);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule